// File: doc/BRIEF.md
# Page Table Entry Permission and Reference Checker

This block decides whether one memory access may use one leaf page table entry. It takes the 64-bit entry, the access kind (load, store or instruction fetch), a user-mode flag, a flag that marks the check as partition-scoped rather than process-scoped, and a 3-bit permission mask supplied by the authority-mask register. From these it produces the granted read/write/execute set, a fault flag and a 4-bit cause word. Separately, it reports whether the entry's reference and change bits already suit the access, so that a walker knows whether the entry must be updated before the access goes ahead.

The decision logic is purely combinational. A parameter adds one register stage on all outputs, with an active-low asynchronous reset that clears them. Walking the table, raising interrupts and writing back the reference/change bits are left to the surrounding logic.

Top module: `pte_access_checker`

## Requirements
- R1: In a process-scoped check (part_i=0) of a user-mode access (user_i=1) to an entry whose privileged bit pte_i[3] is set, the granted set perm_o is 3'b000.
- R2: Otherwise, when user_i=1, pte_i[3]=1 or part_i=1, perm_o equals the entry's authority bits pte_i[2:0], ordered {read, write, execute}.
- R3: For a supervisor access (user_i=0) to a non-privileged entry in a process-scoped check, perm_o is pte_i[2:0] AND amr_i, with amr_i ordered {read, write, execute}.
- R4: The needed permission is read for a load (acc_i=2'b00), write for a store (2'b01) and execute for a fetch (2'b10). Code 2'b11 is handled as a load. If the needed bit is absent from perm_o, a fetch sets cause_o[0] (guarded/no-execute) and a load or store sets cause_o[1] (protection).
- R5: A fetch from an entry whose attribute field pte_i[5:4] equals 2'b10 (non-idempotent I/O) sets cause_o[0] whatever the granted permissions are. Loads and stores ignore that attribute.
- R6: rc_ok_o is 1 for a store only when both the reference bit pte_i[8] and the change bit pte_i[7] are set. For any other access code it is 1 when pte_i[8] is set. cause_o[3] (atomic reference/change) equals !rc_ok_o.
- R7: cause_o[2] (store indicator) is 1 exactly when the access is a store and cause_o[1] or cause_o[3] is set.
- R8: With OUT_REG=1, every output shows the result for the inputs present at the preceding rising clock edge. While rst_ni is low, every output is 0.
- R9: fault_o is 1 exactly when cause_o[0] or cause_o[1] is set. A reference/change shortfall alone does not raise fault_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output stage |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pte_i | input | 64 | Page table entry under test |
| acc_i | input | 2 | Access kind: 00 load, 01 store, 10 fetch, 11 as load |
| user_i | input | 1 | Access made in user (problem) state |
| part_i | input | 1 | Check is partition-scoped |
| amr_i | input | 3 | Authority-mask permissions {R,W,X} |
| perm_o | output | 3 | Granted permissions {R,W,X} |
| fault_o | output | 1 | Permission or guard fault |
| cause_o | output | 4 | {atomic R/C, store, protection, guard/no-exec} |
| rc_ok_o | output | 1 | Reference/change bits already adequate |

## Verification
A wrong branch in the permission-grant priority shows up as a bad perm_o, and, when the needed bit flips, as a wrong fault_o and cause_o. All of this appears one clock after the inputs settle, with nothing built up over time that could hide it. A wrong selection of the needed permission, a guard override applied to data accesses, or a dropped store indicator each show up in the cause word for that same access. The table vectors are chosen so that every combining branch both grants and denies at least once.

// File: rtl/pte_chk_pkg.sv
package pte_chk_pkg;
  localparam int PTE_W      = 64;
  localparam int PERM_W     = 3;
  localparam int CAUSE_W    = 4;
  localparam int AUTH_LO    = 0;
  localparam int PRIV_BIT   = 3;
  localparam int ATTR_LO    = 4;
  localparam int ATTR_W     = 2;
  localparam int CHG_BIT    = 7;
  localparam int REF_BIT    = 8;
  localparam logic [ATTR_W-1:0] ATTR_NI_IO = 2'b10;

  localparam int P_R = 2;
  localparam int P_W = 1;
  localparam int P_X = 0;

  localparam int CS_GUARD = 0;
  localparam int CS_PROT  = 1;
  localparam int CS_STORE = 2;
  localparam int CS_RC    = 3;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  typedef logic [PERM_W-1:0] perm_t;
endpackage

// File: rtl/pte_perm_grant.sv
module pte_perm_grant
  import pte_chk_pkg::*;
(
  input  perm_t auth_i,
  input  logic  priv_i,
  input  logic  user_i,
  input  logic  part_i,
  input  perm_t amr_i,
  output perm_t perm_o
);
  always_comb begin
    if (!part_i && priv_i && user_i)
      perm_o = '0;
    else if (user_i || priv_i || part_i)
      perm_o = auth_i;
    else
      perm_o = auth_i & amr_i;  // least of entry and mask
  end
endmodule

// File: rtl/pte_fault_eval.sv
module pte_fault_eval
  import pte_chk_pkg::*;
(
  input  acc_e              acc_i,
  input  logic [ATTR_W-1:0] attr_i,
  input  perm_t             perm_i,
  output logic              guard_o,
  output logic              prot_o
);
  perm_t need;
  logic  is_fetch;
  logic  io_fetch;
  logic  missing;

  always_comb begin
    need = '0;
    unique case (acc_i)
      ACC_STORE: need[P_W] = 1'b1;
      ACC_FETCH: need[P_X] = 1'b1;
      default:   need[P_R] = 1'b1;
    endcase
  end

  assign is_fetch = (acc_i == ACC_FETCH);
  assign io_fetch = is_fetch && (attr_i == ATTR_NI_IO);
  assign missing  = |(need & ~perm_i);
  assign guard_o  = is_fetch && (io_fetch || missing);
  assign prot_o   = !is_fetch && missing;
endmodule

// File: rtl/pte_rc_eval.sv
module pte_rc_eval
  import pte_chk_pkg::*;
(
  input  acc_e acc_i,
  input  logic ref_i,
  input  logic chg_i,
  output logic rc_ok_o
);
  assign rc_ok_o = ref_i && ((acc_i != ACC_STORE) || chg_i);
endmodule

// File: rtl/pte_access_checker.sv
module pte_access_checker
  import pte_chk_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PTE_W-1:0]   pte_i,
  input  logic [1:0]         acc_i,
  input  logic               user_i,
  input  logic               part_i,
  input  logic [PERM_W-1:0]  amr_i,
  output logic [PERM_W-1:0]  perm_o,
  output logic               fault_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               rc_ok_o
);
  acc_e   acc;
  perm_t  perm_c;
  logic   guard_c, prot_c, rc_ok_c;
  logic [CAUSE_W-1:0] cause_c;

  assign acc = acc_e'(acc_i);

  pte_perm_grant u_grant (
    .auth_i (pte_i[AUTH_LO +: PERM_W]),
    .priv_i (pte_i[PRIV_BIT]),
    .user_i (user_i),
    .part_i (part_i),
    .amr_i  (amr_i),
    .perm_o (perm_c)
  );

  pte_fault_eval u_fault (
    .acc_i   (acc),
    .attr_i  (pte_i[ATTR_LO +: ATTR_W]),
    .perm_i  (perm_c),
    .guard_o (guard_c),
    .prot_o  (prot_c)
  );

  pte_rc_eval u_rc (
    .acc_i   (acc),
    .ref_i   (pte_i[REF_BIT]),
    .chg_i   (pte_i[CHG_BIT]),
    .rc_ok_o (rc_ok_c)
  );

  always_comb begin
    cause_c           = '0;
    cause_c[CS_GUARD] = guard_c;
    cause_c[CS_PROT]  = prot_c;
    cause_c[CS_RC]    = !rc_ok_c;
    cause_c[CS_STORE] = (acc == ACC_STORE) && (prot_c || !rc_ok_c);
  end

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          perm_o  <= '0;
          fault_o <= 1'b0;
          cause_o <= '0;
          rc_ok_o <= 1'b0;
        end else begin
          perm_o  <= perm_c;
          fault_o <= guard_c | prot_c;
          cause_o <= cause_c;
          rc_ok_o <= rc_ok_c;
        end
      end
    end else begin : g_comb
      assign perm_o  = perm_c;
      assign fault_o = guard_c | prot_c;
      assign cause_o = cause_c;
      assign rc_ok_o = rc_ok_c;
    end
  endgenerate
endmodule

// File: rtl/pte_access_checker_chk.sv
module pte_access_checker_chk
  import pte_chk_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [PTE_W-1:0]   pte_i,
  input logic [1:0]         acc_i,
  input logic [PERM_W-1:0]  perm_o,
  input logic               fault_o,
  input logic [CAUSE_W-1:0] cause_o,
  input logic               rc_ok_o
);
  AST_FAULT_NEEDS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (cause_o[CS_GUARD] | cause_o[CS_PROT]));  // R9
  AST_CAUSE_NEEDS_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_o[CS_GUARD] | cause_o[CS_PROT]) |-> fault_o);  // R9
  AST_RC_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rc_ok_o |-> !cause_o[CS_RC]);  // R6
  AST_STORE_BIT_REASON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_o[CS_STORE] |-> (cause_o[CS_PROT] | cause_o[CS_RC]));  // R7
  AST_GUARD_PROT_SPLIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cause_o[CS_GUARD] && cause_o[CS_PROT]));  // R4

  generate
    if (OUT_REG) begin : g_seq
      AST_PERM_WITHIN_AUTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |=> ((perm_o & ~$past(pte_i[AUTH_LO +: PERM_W])) == '0));  // R2
      AST_GUARD_ONLY_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |=> (cause_o[CS_GUARD] -> ($past(acc_i) == 2'b10)));  // R5
    end else begin : g_comb
      AST_PERM_WITHIN_AUTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (perm_o & ~pte_i[AUTH_LO +: PERM_W]) == '0);  // R2
      AST_GUARD_ONLY_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cause_o[CS_GUARD] |-> (acc_i == 2'b10));  // R5
    end
  endgenerate
endmodule

bind pte_access_checker pte_access_checker_chk #(.OUT_REG(OUT_REG)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .pte_i   (pte_i),
  .acc_i   (acc_i),
  .perm_o  (perm_o),
  .fault_o (fault_o),
  .cause_o (cause_o),
  .rc_ok_o (rc_ok_o)
);

// File: tb/pte_access_checker_test.sv
module pte_access_checker_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] pte_i = '0;
  logic [1:0]  acc_i = '0;
  logic        user_i = 1'b0;
  logic        part_i = 1'b0;
  logic [2:0]  amr_i = '0;
  logic [2:0]  perm_o;
  logic        fault_o;
  logic [3:0]  cause_o;
  logic        rc_ok_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int cycles = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  pte_access_checker #(.OUT_REG(1'b1)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pte_i(pte_i), .acc_i(acc_i),
    .user_i(user_i), .part_i(part_i), .amr_i(amr_i),
    .perm_o(perm_o), .fault_o(fault_o), .cause_o(cause_o), .rc_ok_o(rc_ok_o)
  );

  typedef struct packed {
    logic [63:0] pte;
    logic [1:0]  acc;
    logic        user;
    logic        part;
    logic [2:0]  amr;
    logic [2:0]  perm;
    logic        fault;
    logic [3:0]  cause;
    logic        rc_ok;
  } vec_t;

  localparam int NV = 12;
  // pte: [8]=ref [7]=chg [5:4]=attr [3]=priv [2:0]=auth {R,W,X}
  // cause: [3]=rc [2]=store [1]=prot [0]=guard
  localparam vec_t VECS [NV] = '{
    '{64'h107, 2'b00, 1'b1, 1'b0, 3'b000, 3'b111, 1'b0, 4'b0000, 1'b1}, // R2 user load
    '{64'h107, 2'b01, 1'b0, 1'b0, 3'b101, 3'b101, 1'b1, 4'b1110, 1'b0}, // R3 R7 R6
    '{64'h18F, 2'b01, 1'b1, 1'b0, 3'b111, 3'b000, 1'b1, 4'b0110, 1'b1}, // R1
    '{64'h18F, 2'b01, 1'b1, 1'b1, 3'b000, 3'b111, 1'b0, 4'b0000, 1'b1}, // R2 partition
    '{64'h18F, 2'b10, 1'b0, 1'b0, 3'b000, 3'b111, 1'b0, 4'b0000, 1'b1}, // R2 priv ignores mask
    '{64'h127, 2'b10, 1'b0, 1'b1, 3'b000, 3'b111, 1'b1, 4'b0001, 1'b1}, // R5 io fetch
    '{64'h127, 2'b00, 1'b1, 1'b0, 3'b000, 3'b111, 1'b0, 4'b0000, 1'b1}, // R5 io load ok
    '{64'h006, 2'b10, 1'b1, 1'b0, 3'b000, 3'b110, 1'b1, 4'b1001, 1'b0}, // R4 no exec
    '{64'h006, 2'b11, 1'b1, 1'b0, 3'b000, 3'b110, 1'b0, 4'b1000, 1'b0}, // R4 rsvd as load, R9
    '{64'h107, 2'b00, 1'b0, 1'b0, 3'b011, 3'b011, 1'b1, 4'b0010, 1'b1}, // R3 mask drops read
    '{64'h000, 2'b01, 1'b0, 1'b1, 3'b111, 3'b000, 1'b1, 4'b1110, 1'b0}, // R6 R7
    '{64'h182, 2'b01, 1'b0, 1'b0, 3'b010, 3'b010, 1'b0, 4'b0000, 1'b1}  // R3 R6 store ok
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    pte_i = v.pte; acc_i = v.acc; user_i = v.user; part_i = v.part; amr_i = v.amr;
  endtask

  task automatic check_vec(input vec_t v, input int idx);
    chk($sformatf("R1/R2/R3 perm v%0d", idx), {5'b0, perm_o}, {5'b0, v.perm});
    chk($sformatf("R9 fault v%0d", idx), {7'b0, fault_o}, {7'b0, v.fault});
    chk($sformatf("R4/R5/R7 cause v%0d", idx), {4'b0, cause_o}, {4'b0, v.cause});
    chk($sformatf("R6 rc_ok v%0d", idx), {7'b0, rc_ok_o}, {7'b0, v.rc_ok});
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected <5000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    drive(VECS[2]);
    repeat (3) @(negedge clk_i);
    // R8 reset clears outputs
    chk("R8 reset", {perm_o, fault_o, cause_o}, 8'h00);
    chk("R8 reset rc", {7'b0, rc_ok_o}, 8'h00);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      drive(VECS[i]);
      @(negedge clk_i);
      check_vec(VECS[i], i);
    end

    // R8 latency: last vector result held until the next edge
    @(negedge clk_i);
    drive(VECS[10]);
    #2;
    chk("R8 hold perm", {5'b0, perm_o}, {5'b0, VECS[11].perm});
    chk("R8 hold rc", {7'b0, rc_ok_o}, {7'b0, VECS[11].rc_ok});
    @(negedge clk_i);
    chk("R8 update cause", {4'b0, cause_o}, {4'b0, VECS[10].cause});

    // R8 asynchronous reset mid-run
    drive(VECS[1]);
    @(negedge clk_i);
    #3 rst_ni = 1'b0;
    #2;
    chk("R8 async reset", {perm_o, fault_o, cause_o}, 8'h00);
    chk("R8 async reset rc", {7'b0, rc_ok_o}, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_vec(VECS[1], 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule